// File: doc/BRIEF.md
# DMA Stream Address and Count Engine

This block keeps the moving state of one DMA stream: where the next read comes from, where the next write goes, and how many items are left. A bus-side datapath reports each finished read beat and each finished write beat. The engine steps the matching pointer by one element of that side's own width and counts items down on the write side. Arbitration, the bus protocol and any FIFO storage belong to other blocks.

On a rising edge of the enable input, the engine takes a snapshot of the configuration. Changes to the configuration inputs have no effect until the next enable. The engine supports three completion policies:
- Normal mode stops at zero.
- Circular mode reloads its starting pointers and count, then carries on.
- Double-buffer mode also carries on, but its memory-side pointer alternates between a primary buffer address and an alternate buffer address at every wrap.

Half-transfer, transfer-complete and error flags are sticky. Each one is cleared by a one-cycle pulse on its bit of a clear input.

Top module: `dma_stream_engine`

## Requirements
- R1: While reset is held, both pointers, the remaining count, busy, the buffer select and all three flags read zero.
- R2: When `en` rises and `cfg_items` is nonzero, on the next cycle:
  - busy is 1;
  - `src_addr`, `dst_addr` and `items_left` equal the configured start values;
  - `src_size` and `dst_size` show the configured sizes.
- R3: Each `rd_done` pulse while busy advances `src_addr` by the source element size, provided source increment is set. Size code 0 steps by 1, code 1 by 2, and codes 2 and 3 by 4. With increment clear, the address holds.
- R4: Each `wr_done` pulse while busy advances `dst_addr` by the destination element size, using the same codes as R3. This is independent of the source size. With increment clear, the address holds.
- R5: Each `wr_done` while busy lowers `items_left` by one. In normal mode, the write that takes it to zero clears busy and sets `tc_flag`.
- R6: Dropping `en` while busy clears busy on the next cycle without setting `tc_flag`. Later beats leave the pointers and count unchanged.
- R7: In circular mode, the write that ends a lap does the following:
  - reloads `dst_addr` and `items_left` to their start values;
  - reloads `src_addr` to its start value, plus one step if `rd_done` arrives in the same cycle;
  - keeps busy set and sets `tc_flag`.
- R8: In double-buffer mode, every wrap toggles `buf_sel`. The memory-side pointer reloads from `cfg_alt_addr` when `buf_sel` becomes 1, and from its primary start address when it becomes 0. `cfg_mem_is_dst` selects the memory side: 1 means destination, 0 means source. The other pointer reloads its own start address. `buf_sel` is 0 after every enable.
- R9: `ht_flag` sets when `items_left` drops to the enabled count divided by two, rounded down. In circular mode it sets again on every lap.
- R10: Flags are sticky. `flag_clr` bit 0 clears `ht_flag`, bit 1 clears `tc_flag` and bit 2 clears `err_flag`. A set in the same cycle wins over a clear.
- R11: When `en` rises with `cfg_items` equal to zero, `err_flag` sets and busy stays 0 for as long as `en` stays high.
- R12: Configuration changes while busy have no effect. A new start requires `en` to go low and then high again.
- R13: `rd_done` and `wr_done` pulses while not busy change neither pointer nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src_addr | input | ADDR_W | Source start address |
| cfg_dst_addr | input | ADDR_W | Destination start address |
| cfg_alt_addr | input | ADDR_W | Alternate memory buffer address |
| cfg_items | input | CNT_W | Items per lap |
| cfg_src_size | input | 2 | Source element size code |
| cfg_dst_size | input | 2 | Destination element size code |
| cfg_src_inc | input | 1 | Source increment enable |
| cfg_dst_inc | input | 1 | Destination increment enable |
| cfg_circular | input | 1 | Circular reload mode |
| cfg_dbl_buf | input | 1 | Double-buffer mode (implies circular) |
| cfg_mem_is_dst | input | 1 | Memory side is destination (1) or source (0) |
| en | input | 1 | Stream enable level |
| rd_done | input | 1 | One read beat finished |
| wr_done | input | 1 | One write beat finished |
| flag_clr | input | 3 | Write-one-to-clear for ht, tc, err |
| src_addr | output | ADDR_W | Current source pointer |
| dst_addr | output | ADDR_W | Current destination pointer |
| src_size | output | 2 | Active source size code |
| dst_size | output | 2 | Active destination size code |
| items_left | output | CNT_W | Remaining items in this lap |
| busy | output | 1 | Stream active |
| buf_sel | output | 1 | Memory buffer in use |
| ht_flag | output | 1 | Half-transfer flag |
| tc_flag | output | 1 | Transfer-complete flag |
| err_flag | output | 1 | Zero-count enable error |

## Verification
The address stepping is tried with mismatched widths: half-word reads against word writes, a reserved size code against a non-incrementing destination, and word reads against byte writes. An engine that used one shared step, or stepped a side whose increment is off, gives different pointers. The stream is ended in three ways, by count exhaustion, by dropping the enable and by wrapping, which separates finish, abort and reload, including a read that lands on the wrap cycle. Double buffering is run with the memory on each side in turn, so a swap applied to the wrong pointer shows up. Odd counts and a count of one place the half-transfer point at the boundaries.

// File: rtl/dmae_pkg.sv
`timescale 1ns/1ps
package dmae_pkg;

    typedef enum logic [1:0] {
        ESZ_8   = 2'd0,
        ESZ_16  = 2'd1,
        ESZ_32  = 2'd2,
        ESZ_32X = 2'd3
    } esz_t;

    typedef struct packed {
        esz_t src_sz;
        esz_t dst_sz;
        logic src_inc;
        logic dst_inc;
        logic circ;
        logic dbuf;
        logic mem_dst;
    } mode_t;

    localparam int FLAG_N   = 3;
    localparam int FLAG_HT  = 0;
    localparam int FLAG_TC  = 1;
    localparam int FLAG_ERR = 2;

    // Byte step for one element of the given size; the spare code acts as 32-bit.
    function automatic logic [2:0] esz_step(esz_t s);
        case (s)
            ESZ_8:   return 3'd1;
            ESZ_16:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmae_ptr.sv
`timescale 1ns/1ps
module dmae_ptr
    import dmae_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              reload,
    input  logic [ADDR_W-1:0] reload_addr,
    input  logic              adv,
    input  logic              inc,
    input  esz_t              sz,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] step;
    assign step = inc ? ADDR_W'(esz_step(sz)) : '0;

    always_ff @(posedge clk) begin
        if (rst)          addr <= '0;
        else if (load)    addr <= load_addr;
        else if (reload)  addr <= reload_addr + (adv ? step : '0);
        else if (adv)     addr <= addr + step;
    end

    // Without a beat, a load or a reload the pointer must not move.
    assert_ptr_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (!load && !reload && !adv) |=> $stable(addr));

    // A side with increment disabled keeps its address across beats.
    assert_ptr_noinc_R3: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load && !reload) |=> $stable(addr));

endmodule

// File: rtl/dmae_count.sv
`timescale 1ns/1ps
module dmae_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             rearm,
    output logic [CNT_W-1:0] count,
    output logic             last,
    output logic             at_half
);

    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] count_m1;

    assign count_m1 = count - CNT_W'(1);
    assign last     = (count == CNT_W'(1));
    assign at_half  = dec && (count_m1 == half_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            init_q <= '0;
            half_q <= '0;
        end else if (load) begin
            count  <= load_val;
            init_q <= load_val;
            half_q <= load_val >> 1;
        end else if (dec) begin
            count  <= (last && rearm) ? init_q : count_m1;
        end
    end

    // The remaining count never exceeds what was loaded.
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        count <= init_q);

    // A rearmed final beat restores the full lap count.
    assert_count_rearm_R7: assert property (@(posedge clk) disable iff (rst)
        (dec && last && rearm && !load) |=> count == init_q);

endmodule

// File: rtl/dmae_flags.sv
`timescale 1ns/1ps
module dmae_flags
    import dmae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_ht,
    input  logic              set_tc,
    input  logic              set_err,
    input  logic [FLAG_N-1:0] clr,
    output logic              ht,
    output logic              tc,
    output logic              err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ht  <= 1'b0;
            tc  <= 1'b0;
            err <= 1'b0;
        end else begin
            ht  <= set_ht  | (ht  & ~clr[FLAG_HT]);
            tc  <= set_tc  | (tc  & ~clr[FLAG_TC]);
            err <= set_err | (err & ~clr[FLAG_ERR]);
        end
    end

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (tc && !clr[FLAG_TC]) |=> tc);

    assert_flag_setwins_R10: assert property (@(posedge clk) disable iff (rst)
        set_err |=> err);

endmodule

// File: rtl/dma_stream_engine.sv
`timescale 1ns/1ps
module dma_stream_engine
    import dmae_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [ADDR_W-1:0] cfg_alt_addr,
    input  logic [CNT_W-1:0]  cfg_items,
    input  logic [1:0]        cfg_src_size,
    input  logic [1:0]        cfg_dst_size,
    input  logic              cfg_src_inc,
    input  logic              cfg_dst_inc,
    input  logic              cfg_circular,
    input  logic              cfg_dbl_buf,
    input  logic              cfg_mem_is_dst,
    input  logic              en,
    input  logic              rd_done,
    input  logic              wr_done,
    input  logic [2:0]        flag_clr,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [1:0]        src_size,
    output logic [1:0]        dst_size,
    output logic [CNT_W-1:0]  items_left,
    output logic              busy,
    output logic              buf_sel,
    output logic              ht_flag,
    output logic              tc_flag,
    output logic              err_flag
);

    mode_t             mode_q;
    mode_t             mode_cfg;
    logic [ADDR_W-1:0] src_base_q, dst_base_q, alt_base_q;
    logic              en_q, busy_q, buf_sel_q;

    logic start, load, zero_start, active;
    logic rd_adv, wr_adv, cnt_last, cnt_half, rearm;
    logic wrap_ev, finish, buf_next;
    logic [ADDR_W-1:0] mem_base_next, src_reload, dst_reload;

    assign mode_cfg = '{src_sz:  esz_t'(cfg_src_size),
                        dst_sz:  esz_t'(cfg_dst_size),
                        src_inc: cfg_src_inc,
                        dst_inc: cfg_dst_inc,
                        circ:    cfg_circular,
                        dbuf:    cfg_dbl_buf,
                        mem_dst: cfg_mem_is_dst};

    // Control decode
    assign start      = en && !en_q;
    assign zero_start = start && (cfg_items == '0);
    assign load       = start && (cfg_items != '0);
    assign active     = busy_q && en;
    assign rd_adv     = active && rd_done;
    assign wr_adv     = active && wr_done;
    assign rearm      = mode_q.circ || mode_q.dbuf;
    assign wrap_ev    = wr_adv && cnt_last && rearm;
    assign finish     = wr_adv && cnt_last && !rearm;

    // Reload targets at a wrap
    assign buf_next      = mode_q.dbuf ? ~buf_sel_q : buf_sel_q;
    assign mem_base_next = buf_next ? alt_base_q
                                    : (mode_q.mem_dst ? dst_base_q : src_base_q);
    assign src_reload    = (mode_q.dbuf && !mode_q.mem_dst) ? mem_base_next : src_base_q;
    assign dst_reload    = (mode_q.dbuf &&  mode_q.mem_dst) ? mem_base_next : dst_base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            busy_q     <= 1'b0;
            buf_sel_q  <= 1'b0;
            mode_q     <= '0;
            src_base_q <= '0;
            dst_base_q <= '0;
            alt_base_q <= '0;
        end else begin
            en_q <= en;
            if (load) begin
                busy_q     <= 1'b1;
                buf_sel_q  <= 1'b0;
                mode_q     <= mode_cfg;
                src_base_q <= cfg_src_addr;
                dst_base_q <= cfg_dst_addr;
                alt_base_q <= cfg_alt_addr;
            end else begin
                if (!en || finish) busy_q <= 1'b0;
                if (wrap_ev)       buf_sel_q <= buf_next;
            end
        end
    end

    // Per-side pointers
    dmae_ptr #(.ADDR_W(ADDR_W)) u_src_ptr (
        .clk(clk), .rst(rst),
        .load(load), .load_addr(cfg_src_addr),
        .reload(wrap_ev), .reload_addr(src_reload),
        .adv(rd_adv), .inc(mode_q.src_inc), .sz(mode_q.src_sz),
        .addr(src_addr)
    );

    dmae_ptr #(.ADDR_W(ADDR_W)) u_dst_ptr (
        .clk(clk), .rst(rst),
        .load(load), .load_addr(cfg_dst_addr),
        .reload(wrap_ev), .reload_addr(dst_reload),
        .adv(wr_adv && !wrap_ev), .inc(mode_q.dst_inc), .sz(mode_q.dst_sz),
        .addr(dst_addr)
    );

    dmae_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst),
        .load(load), .load_val(cfg_items),
        .dec(wr_adv), .rearm(rearm),
        .count(items_left), .last(cnt_last), .at_half(cnt_half)
    );

    dmae_flags u_flags (
        .clk(clk), .rst(rst),
        .set_ht(cnt_half), .set_tc(wr_adv && cnt_last), .set_err(zero_start),
        .clr(flag_clr),
        .ht(ht_flag), .tc(tc_flag), .err(err_flag)
    );

    assign busy     = busy_q;
    assign buf_sel  = buf_sel_q;
    assign src_size = mode_q.src_sz;
    assign dst_size = mode_q.dst_sz;

    assert_zero_err_R11: assert property (@(posedge clk) disable iff (rst)
        zero_start |=> (err_flag && !busy));

    assert_drop_en_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);

    assert_busy_count_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (items_left != '0));

    assert_finish_R5: assert property (@(posedge clk) disable iff (rst)
        finish |=> (tc_flag && !busy));

    assert_wrap_busy_R7: assert property (@(posedge clk) disable iff (rst)
        wrap_ev |=> (busy && tc_flag));

    assert_bufsel_R8: assert property (@(posedge clk) disable iff (rst)
        !mode_q.dbuf |-> !buf_sel_q);

endmodule

// File: tb/tb_dma_stream_engine.sv
`timescale 1ns/1ps
module tb_dma_stream_engine;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] cfg_src_addr = '0, cfg_dst_addr = '0, cfg_alt_addr = '0;
    logic [CNT_W-1:0]  cfg_items = '0;
    logic [1:0]        cfg_src_size = '0, cfg_dst_size = '0;
    logic              cfg_src_inc = 0, cfg_dst_inc = 0, cfg_circular = 0;
    logic              cfg_dbl_buf = 0, cfg_mem_is_dst = 0;
    logic              en = 0, rd_done = 0, wr_done = 0;
    logic [2:0]        flag_clr = '0;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [1:0]        src_size, dst_size;
    logic [CNT_W-1:0]  items_left;
    logic              busy, buf_sel, ht_flag, tc_flag, err_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dma_stream_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (.*);

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_done = 1'b1;
        @(negedge clk) rd_done = 1'b0;
    endtask

    task automatic pulse_wr();
        @(negedge clk) wr_done = 1'b1;
        @(negedge clk) wr_done = 1'b0;
    endtask

    task automatic pulse_both();
        @(negedge clk) begin rd_done = 1'b1; wr_done = 1'b1; end
        @(negedge clk) begin rd_done = 1'b0; wr_done = 1'b0; end
    endtask

    task automatic go();
        @(negedge clk) en = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop();
        @(negedge clk) en = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flags(logic [2:0] m);
        @(negedge clk) flag_clr = m;
        @(negedge clk) flag_clr = '0;
    endtask

    task automatic t_reset();
        chk("R1", "src_addr", src_addr, 0);
        chk("R1", "dst_addr", dst_addr, 0);
        chk("R1", "items", items_left, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "buf_sel", buf_sel, 0);
        chk("R1", "flags", {ht_flag, tc_flag, err_flag}, 0);
    endtask

    task automatic t_mixed_sizes();
        cfg_src_addr = 32'h1000; cfg_src_size = 2'd1; cfg_src_inc = 1;
        cfg_dst_addr = 32'h2000; cfg_dst_size = 2'd2; cfg_dst_inc = 1;
        cfg_items = 4; cfg_circular = 0; cfg_dbl_buf = 0;
        go();
        chk("R2", "busy", busy, 1);
        chk("R2", "src start", src_addr, 32'h1000);
        chk("R2", "dst start", dst_addr, 32'h2000);
        chk("R2", "items", items_left, 4);
        chk("R2", "sizes", {src_size, dst_size}, {2'd1, 2'd2});
        pulse_rd(); pulse_rd();
        chk("R3", "src half step", src_addr, 32'h1004);
        pulse_wr();
        chk("R4", "dst word step", dst_addr, 32'h2004);
        chk("R5", "items dec", items_left, 3);
        chk("R9", "ht early", ht_flag, 0);
        pulse_wr();
        chk("R9", "ht at half", ht_flag, 1);
        chk("R5", "tc early", tc_flag, 0);
        pulse_wr(); pulse_wr();
        chk("R5", "done busy", busy, 0);
        chk("R5", "done tc", tc_flag, 1);
        chk("R5", "done items", items_left, 0);
        chk("R4", "dst end", dst_addr, 32'h2010);
        pulse_rd(); pulse_wr();
        chk("R13", "idle src", src_addr, 32'h1004);
        chk("R13", "idle dst", dst_addr, 32'h2010);
        chk("R13", "idle items", items_left, 0);
        stop();
        clear_flags(3'b011);
        chk("R10", "ht/tc cleared", {ht_flag, tc_flag}, 0);
    endtask

    task automatic t_abort_and_snapshot();
        cfg_src_addr = 32'h10; cfg_src_size = 2'd3; cfg_src_inc = 1;
        cfg_dst_addr = 32'h40; cfg_dst_size = 2'd2; cfg_dst_inc = 0;
        cfg_items = 3;
        go();
        pulse_rd();
        chk("R3", "spare code step", src_addr, 32'h14);
        pulse_wr();
        chk("R4", "dst no inc", dst_addr, 32'h40);
        chk("R5", "items", items_left, 2);
        @(negedge clk) begin cfg_src_addr = 32'h500; cfg_src_size = 2'd0; end
        pulse_rd();
        chk("R12", "src ignores cfg", src_addr, 32'h18);
        chk("R12", "size latched", src_size, 2'd3);
        stop();
        chk("R6", "abort busy", busy, 0);
        chk("R6", "abort no tc", tc_flag, 0);
        pulse_wr(); pulse_rd();
        chk("R6", "post-abort items", items_left, 2);
        chk("R6", "post-abort src", src_addr, 32'h18);
        go();
        chk("R12", "restart src", src_addr, 32'h500);
        chk("R12", "restart items", items_left, 3);
        chk("R12", "restart size", src_size, 2'd0);
        stop();
    endtask

    task automatic t_circular();
        cfg_src_addr = 32'h100; cfg_src_size = 2'd2; cfg_src_inc = 1;
        cfg_dst_addr = 32'h200; cfg_dst_size = 2'd0; cfg_dst_inc = 1;
        cfg_items = 2; cfg_circular = 1;
        go();
        pulse_rd(); pulse_wr();
        chk("R4", "dst byte step", dst_addr, 32'h201);
        chk("R9", "ht count2", ht_flag, 1);
        pulse_rd(); pulse_wr();
        chk("R7", "wrap src", src_addr, 32'h100);
        chk("R7", "wrap dst", dst_addr, 32'h200);
        chk("R7", "wrap items", items_left, 2);
        chk("R7", "wrap busy", busy, 1);
        chk("R7", "wrap tc", tc_flag, 1);
        pulse_rd(); pulse_wr();
        pulse_both();
        chk("R7", "wrap+rd src", src_addr, 32'h104);
        chk("R7", "wrap+rd dst", dst_addr, 32'h200);
        chk("R7", "wrap+rd items", items_left, 2);
        stop();
        clear_flags(3'b111);
        cfg_circular = 0;
    endtask

    task automatic t_double_buffer();
        cfg_src_addr = 32'h300; cfg_src_size = 2'd2; cfg_src_inc = 0;
        cfg_dst_addr = 32'h800; cfg_dst_size = 2'd1; cfg_dst_inc = 1;
        cfg_alt_addr = 32'h900; cfg_items = 1; cfg_dbl_buf = 1; cfg_mem_is_dst = 1;
        go();
        chk("R8", "start buf", buf_sel, 0);
        pulse_wr();
        chk("R8", "swap dst alt", dst_addr, 32'h900);
        chk("R8", "buf toggled", buf_sel, 1);
        chk("R8", "src kept", src_addr, 32'h300);
        chk("R9", "ht count1", ht_flag, 1);
        chk("R8", "still busy", busy, 1);
        pulse_wr();
        chk("R8", "swap dst back", dst_addr, 32'h800);
        chk("R8", "buf back", buf_sel, 0);
        stop();
        cfg_src_inc = 1; cfg_alt_addr = 32'h700; cfg_mem_is_dst = 0;
        go();
        pulse_rd(); pulse_wr();
        chk("R8", "swap src alt", src_addr, 32'h700);
        chk("R8", "dst reloads", dst_addr, 32'h800);
        chk("R8", "buf src side", buf_sel, 1);
        stop();
        go();
        chk("R8", "buf reset on enable", buf_sel, 0);
        chk("R8", "src primary", src_addr, 32'h300);
        stop();
        clear_flags(3'b111);
        cfg_dbl_buf = 0;
    endtask

    task automatic t_zero_count();
        cfg_items = 0;
        go();
        chk("R11", "err set", err_flag, 1);
        chk("R11", "not busy", busy, 0);
        tick();
        chk("R11", "stays idle", busy, 0);
        @(negedge clk) begin en = 0; flag_clr = 3'b100; end
        @(negedge clk) flag_clr = 3'b000;
        chk("R10", "err cleared", err_flag, 0);
        @(negedge clk) begin en = 1; flag_clr = 3'b100; end
        @(negedge clk) flag_clr = 3'b000;
        chk("R10", "set wins", err_flag, 1);
        stop();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        @(negedge clk) rst = 1'b0;
        tick();
        t_mixed_sizes();
        t_abort_and_snapshot();
        t_circular();
        t_double_buffer();
        t_zero_count();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule